// File: doc/BRIEF.md
# Target Read Return Formatter

This block serves read requests that arrive on a host-target port and answers each one with a single 64-bit return beat. The data in that beat always sits in quadword lanes, whatever the request address. The storage behind the block is a synchronous memory that is 32 bits wide and has a read strobe for each byte. That strobe lets the block touch only the bytes that were asked for, so registers with read side effects stay safe.

Each request carries four things: a byte address, eight quadword-aligned byte enables, a 4-bit tag and an 8-bit control byte. A request transfers in the cycle where enable and accept are both high. Control bit 0 asks for both dwords of the quadword. This is used for quadword reads and for dword reads that straddle a dword boundary. In that case the block makes two backend reads, merges the results and returns them together. Otherwise one dword is read and placed in the lane given by address bit 2. Bytes that were not requested return as zero. The tag and the control byte travel back with the data unchanged.

Only one request is in flight at a time. Accept is held low from the transfer until the return beat has gone out, so the returns come back in the same order as the requests.

Top module: `tgt_rd_fmt`

## Requirements
- R1: `req_accept` is high after reset. It goes low in the cycle after a request transfers (`req_en` and `req_accept` both high at a clock edge). It stays low through the return-beat cycle and rises in the cycle after it. A request held on `req_en` while accept is low has no effect.
- R2: Control bit 0 clear and address bit 2 clear: the block makes one backend read of dword `req_addr[ADDR_W-1:2]` with strobe `req_be[3:0]`. The data is returned in bits 31:0.
- R3: Control bit 0 clear and address bit 2 set: the block makes one backend read of that dword with strobe `req_be[7:4]`. The data is returned in bits 63:32, and bits 31:0 are zero.
- R4: Control bit 0 set: the block makes two backend reads on consecutive cycles. The first is the even dword of the quadword, with strobe `req_be[3:0]`. The second is the odd dword, with strobe `req_be[7:4]`. The even dword is returned in bits 31:0 and the odd dword in bits 63:32.
- R5: Every returned byte whose byte enable was 0 reads as zero. Return byte k is bits 8k+7:8k and is governed by `req_be[k]`.
- R6: `ret_tag` and `ret_ctrl` in a return beat equal the tag and the control byte captured when that request transferred.
- R7: `ret_valid` is a one-cycle pulse. It is high 3 cycles after the transfer edge for a single-dword read and 4 cycles after it for a two-dword read.
- R8: Every transferred request produces exactly one return beat, and beats leave in request order.
- R9: `mem_rd_en` is high only in the read cycles given in R2 to R4. `mem_strb` is zero whenever `mem_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_en | input | 1 | Read request present |
| req_accept | output | 1 | Block can take a request |
| req_addr | input | ADDR_W-2 | Byte address bits ADDR_W-1:2 |
| req_be | input | 8 | Quadword-aligned byte enables |
| req_tag | input | 4 | Request tag |
| req_ctrl | input | 8 | Control byte; bit 0 = read both dwords |
| mem_rd_en | output | 1 | Backend read strobe |
| mem_addr | output | ADDR_W-2 | Backend dword address |
| mem_strb | output | 4 | Backend per-byte read strobe |
| mem_rdata | input | 32 | Backend data, one cycle after the read |
| ret_valid | output | 1 | Return beat valid |
| ret_data | output | 64 | Quadword-aligned return data |
| ret_tag | output | 4 | Echoed tag |
| ret_ctrl | output | 8 | Echoed control byte |

## Verification
A sequencer that is in the wrong state shows up first on the backend port. A read appears in the wrong cycle, or with the wrong strobe nibble, one cycle after the transfer edge. It also shows up as `req_accept` high when it should be low, which lets an extra request slip in. A lane register with the wrong select or a stale mask shows up in the next return beat, 3 or 4 cycles after the transfer: a dword in the wrong half, a byte that should be zero, or a word left over from an earlier request. The reference model predicts the accept level, the backend access and the return-beat contents for every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/tgt_rd_pkg.sv
// Shared types and helpers for the target read return formatter.
// Assumes a 64-bit return beat split into 32-bit dword lanes.
package tgt_rd_pkg;

    localparam int DW_BITS  = 32;
    localparam int QW_BITS  = 64;
    localparam int NLANES   = QW_BITS / DW_BITS;
    localparam int DW_BYTES = DW_BITS / 8;

    // Sequencer phases: wait, read first dword, read second dword,
    // capture last data, present the return beat.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD0  = 3'd1,
        ST_RD1  = 3'd2,
        ST_LAST = 3'd3,
        ST_RET  = 3'd4
    } seq_st_t;

    // Widen a byte-strobe nibble into a dword bit mask.
    function automatic logic [DW_BITS-1:0] byte_mask(input logic [DW_BYTES-1:0] s);
        logic [DW_BITS-1:0] m;
        for (int b = 0; b < DW_BYTES; b++) begin
            m[b*8 +: 8] = {8{s[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/tgt_rd_seq.sv
// Request sequencer: takes one read request at a time, issues one or two
// backend dword reads and tells the lane store which lane to load.
// Assumes the backend returns data in the cycle after the read strobe.
module tgt_rd_seq
    import tgt_rd_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int MA_W  = ADDR_W - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_en,
    output logic                req_accept,
    input  logic [MA_W-1:0]     req_addr,
    input  logic [7:0]          req_be,
    input  logic [3:0]          req_tag,
    input  logic [7:0]          req_ctrl,
    output logic                mem_rd_en,
    output logic [MA_W-1:0]     mem_addr,
    output logic [3:0]          mem_strb,
    output logic                load,
    output logic [NLANES-1:0]   lane_wr,
    output logic [7:0]          be_q,
    output logic                ret_valid,
    output logic [3:0]          tag_q,
    output logic [7:0]          ctrl_q
);

    seq_st_t         st, st_nx;
    logic [MA_W-1:0] dw_q;
    logic            pair;
    logic [MA_W-1:0] even_dw;

    assign req_accept = (st == ST_IDLE);
    assign load       = req_en && req_accept;
    assign pair       = ctrl_q[0];
    assign even_dw    = {dw_q[MA_W-1:1], 1'b0};
    assign ret_valid  = (st == ST_RET);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next phase: two reads for a pair request, one otherwise.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (load) st_nx = ST_RD0;
            ST_RD0:  st_nx = pair ? ST_RD1 : ST_LAST;
            ST_RD1:  st_nx = ST_LAST;
            ST_LAST: st_nx = ST_RET;
            ST_RET:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Capture the request fields on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_q   <= '0;
            be_q   <= '0;
            tag_q  <= '0;
            ctrl_q <= '0;
        end else if (load) begin
            dw_q   <= req_addr;
            be_q   <= req_be;
            tag_q  <= req_tag;
            ctrl_q <= req_ctrl;
        end
    end

    // Backend access: dword address and strobe nibble for each read phase.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        mem_strb  = '0;
        if (st == ST_RD0) begin
            mem_rd_en = 1'b1;
            mem_addr  = pair ? even_dw : dw_q;
            mem_strb  = (!pair && dw_q[0]) ? be_q[7:4] : be_q[3:0];
        end else if (st == ST_RD1) begin
            mem_rd_en = 1'b1;
            mem_addr  = {dw_q[MA_W-1:1], 1'b1};
            mem_strb  = be_q[7:4];
        end
    end

    // Lane select for the data that arrives in this phase.
    always_comb begin
        lane_wr = '0;
        if (st == ST_RD1)                lane_wr[0] = 1'b1;
        else if (st == ST_LAST) begin
            if (pair || dw_q[0])         lane_wr[1] = 1'b1;
            else                         lane_wr[0] = 1'b1;
        end
    end

endmodule

// File: rtl/tgt_rd_lanes.sv
// Lane store: one dword register per quadword lane. Cleared when a request
// transfers, loaded with byte-masked backend data when its lane is selected.
// Assumes the selected lane's byte enables cover exactly the bytes to keep.
module tgt_rd_lanes
    import tgt_rd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NLANES-1:0]  lane_wr,
    input  logic [7:0]         be_q,
    input  logic [DW_BITS-1:0] mem_rdata,
    output logic [QW_BITS-1:0] data
);

    for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
        logic [DW_BITS-1:0] word_q;

        // Hold one lane: zero on a new request, masked data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || load)   word_q <= '0;
            else if (lane_wr[ln]) word_q <= mem_rdata & byte_mask(be_q[ln*DW_BYTES +: DW_BYTES]);
        end

        assign data[ln*DW_BITS +: DW_BITS] = word_q;
    end

endmodule

// File: rtl/tgt_rd_fmt.sv
// Top of the target read return formatter: sequencer plus lane store.
// Assumes one request in flight and a one-cycle-latency backend.
module tgt_rd_fmt
    import tgt_rd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    output logic              req_accept,
    input  logic [ADDR_W-3:0] req_addr,
    input  logic [7:0]        req_be,
    input  logic [3:0]        req_tag,
    input  logic [7:0]        req_ctrl,
    output logic              mem_rd_en,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_strb,
    input  logic [31:0]       mem_rdata,
    output logic              ret_valid,
    output logic [63:0]       ret_data,
    output logic [3:0]        ret_tag,
    output logic [7:0]        ret_ctrl
);

    logic              load;
    logic [NLANES-1:0] lane_wr;
    logic [7:0]        be_q;

    tgt_rd_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_en     (req_en),
        .req_accept (req_accept),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_tag    (req_tag),
        .req_ctrl   (req_ctrl),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_strb   (mem_strb),
        .load       (load),
        .lane_wr    (lane_wr),
        .be_q       (be_q),
        .ret_valid  (ret_valid),
        .tag_q      (ret_tag),
        .ctrl_q     (ret_ctrl)
    );

    tgt_rd_lanes i_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .lane_wr   (lane_wr),
        .be_q      (be_q),
        .mem_rdata (mem_rdata),
        .data      (ret_data)
    );

endmodule

// File: rtl/tgt_rd_fmt_chk.sv
// Port-level checker for tgt_rd_fmt, bound into every instance.
// Keeps its own copy of the request fields taken at each transfer.
module tgt_rd_fmt_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_en,
    input logic              req_accept,
    input logic [ADDR_W-3:0] req_addr,
    input logic [7:0]        req_be,
    input logic [3:0]        req_tag,
    input logic [7:0]        req_ctrl,
    input logic              mem_rd_en,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_strb,
    input logic              ret_valid,
    input logic [63:0]       ret_data,
    input logic [3:0]        ret_tag,
    input logic [7:0]        ret_ctrl
);

    logic [3:0] c_tag;
    logic [7:0] c_ctrl;
    logic [7:0] c_be;
    logic       c_hi;
    logic [63:0] zero_mask;

    // Record the fields of each transferred request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_tag <= '0; c_ctrl <= '0; c_be <= '0; c_hi <= 1'b0;
        end else if (req_en && req_accept) begin
            c_tag <= req_tag; c_ctrl <= req_ctrl; c_be <= req_be; c_hi <= req_addr[0];
        end
    end

    // Bytes that must read as zero.
    always_comb begin
        for (int b = 0; b < 8; b++) zero_mask[b*8 +: 8] = {8{!c_be[b]}};
    end

    a_r1_busy_after_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_accept) |=> !req_accept);
    a_r1_no_accept_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !req_accept);
    a_r1_accept_after_return: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> req_accept);
    a_r3_low_lane_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !c_ctrl[0] && c_hi) |-> (ret_data[31:0] == 32'h0));
    a_r4_second_read_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && c_ctrl[0] && !mem_addr[0]) |=>
        (mem_rd_en && mem_addr[0] && (mem_addr[ADDR_W-3:1] == $past(mem_addr[ADDR_W-3:1]))));
    a_r5_masked_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((ret_data & zero_mask) == 64'h0));
    a_r6_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_tag == c_tag && ret_ctrl == c_ctrl));
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);
    a_r7_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en)));
    a_r9_strobe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strb != 4'h0) |-> mem_rd_en);

endmodule

bind tgt_rd_fmt tgt_rd_fmt_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_en     (req_en),
    .req_accept (req_accept),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_tag    (req_tag),
    .req_ctrl   (req_ctrl),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_strb   (mem_strb),
    .ret_valid  (ret_valid),
    .ret_data   (ret_data),
    .ret_tag    (ret_tag),
    .ret_ctrl   (ret_ctrl)
);

// File: tb/test_tgt_rd_fmt.sv
// Bench: behavioural per-cycle schedule of expected accept, backend reads
// and return beats, compared at every falling edge.
module test_tgt_rd_fmt;

    localparam int ADDR_W = 12;
    localparam int NDW    = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_en = 1'b0;
    logic              req_accept;
    logic [ADDR_W-3:0] req_addr = '0;
    logic [7:0]        req_be = '0;
    logic [3:0]        req_tag = '0;
    logic [7:0]        req_ctrl = '0;
    logic              mem_rd_en;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_strb;
    logic [31:0]       mem_rdata = '0;
    logic              ret_valid;
    logic [63:0]       ret_data;
    logic [3:0]        ret_tag;
    logic [7:0]        ret_ctrl;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int free_cyc = 0;
    bit done = 1'b0;

    logic [31:0] mem [NDW];
    logic [ADDR_W-3:0] exp_ra [int];
    logic [3:0]        exp_rs [int];
    logic [63:0]       exp_d  [int];
    logic [3:0]        exp_t  [int];
    logic [7:0]        exp_c  [int];
    string             exp_l  [int];

    always #2ns clk = ~clk;

    tgt_rd_fmt #(.ADDR_W(ADDR_W)) i_tgt_rd_fmt (.*);

    // Backend memory with one cycle of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] msk(input logic [31:0] w, input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = s[b] ? w[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    // Reference model and per-cycle comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 accept", req_accept, cyc >= free_cyc);
            chk("R9 read strobe", mem_rd_en, exp_ra.exists(cyc));
            if (mem_rd_en && exp_ra.exists(cyc)) begin
                chk("R4 R9 read address", mem_addr, exp_ra[cyc]);
                chk("R9 byte strobe", mem_strb, exp_rs[cyc]);
            end
            if (!mem_rd_en) chk("R9 idle strobe", mem_strb, 4'h0);
            chk("R7 R8 return valid", ret_valid, exp_d.exists(cyc));
            if (ret_valid && exp_d.exists(cyc)) begin
                chk(exp_l[cyc], ret_data, exp_d[cyc]);
                chk("R6 R8 tag", ret_tag, exp_t[cyc]);
                chk("R6 control", ret_ctrl, exp_c[cyc]);
            end
            if (req_en && req_accept) begin
                automatic int lat = req_ctrl[0] ? 4 : 3;
                automatic logic [ADDR_W-3:0] ev = {req_addr[ADDR_W-3:1], 1'b0};
                automatic logic [ADDR_W-3:0] od = {req_addr[ADDR_W-3:1], 1'b1};
                if (req_ctrl[0]) begin
                    exp_ra[cyc+1] = ev; exp_rs[cyc+1] = req_be[3:0];
                    exp_ra[cyc+2] = od; exp_rs[cyc+2] = req_be[7:4];
                    exp_d[cyc+lat] = {msk(mem[od], req_be[7:4]), msk(mem[ev], req_be[3:0])};
                    exp_l[cyc+lat] = "R4 R5 pair data";
                end else if (req_addr[0]) begin
                    exp_ra[cyc+1] = req_addr; exp_rs[cyc+1] = req_be[7:4];
                    exp_d[cyc+lat] = {msk(mem[req_addr], req_be[7:4]), 32'h0};
                    exp_l[cyc+lat] = "R3 R5 high lane data";
                end else begin
                    exp_ra[cyc+1] = req_addr; exp_rs[cyc+1] = req_be[3:0];
                    exp_d[cyc+lat] = {32'h0, msk(mem[req_addr], req_be[3:0])};
                    exp_l[cyc+lat] = "R2 R5 low lane data";
                end
                exp_t[cyc+lat] = req_tag;
                exp_c[cyc+lat] = req_ctrl;
                free_cyc = cyc + lat + 1;
            end
        end
    end

    // Present a request and hold it until it transfers; caller is at posedge+1.
    task automatic rq(input logic [ADDR_W-1:0] ba, input logic [7:0] be,
                      input logic [3:0] tg, input logic [7:0] ct);
        req_en = 1'b1; req_addr = ba[ADDR_W-1:2]; req_be = be; req_tag = tg; req_ctrl = ct;
        do @(negedge clk); while (!req_accept);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        req_en = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        for (int i = 0; i < NDW; i++) mem[i] = (i * 32'h9E3779B1) ^ (i << 20) ^ 32'h5A00C3F0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 R7 R9: reset state
        chk("R1 reset accept", req_accept, 1'b1);
        chk("R7 reset valid", ret_valid, 1'b0);
        chk("R9 reset read", mem_rd_en, 1'b0);
        @(posedge clk); #1;
        rq(12'h010, 8'h0F, 4'h1, 8'h00);   // R2 low lane
        idle(6);
        rq(12'h014, 8'hF0, 4'h2, 8'h80);   // R3 high lane
        idle(6);
        rq(12'h020, 8'hFF, 4'h3, 8'h01);   // R4 quadword
        idle(6);
        rq(12'h030, 8'h3C, 4'h4, 8'h5B);   // R4 R5 dword crossing boundary
        idle(6);
        rq(12'h044, 8'h60, 4'h9, 8'h00);   // R5 partial high
        idle(6);
        rq(12'h048, 8'h01, 4'hF, 8'hFE);   // R5 R6 single byte, odd control
        // R1 R8: requests held while busy, back to back
        rq(12'h100, 8'hF0, 4'h5, 8'h11);
        rq(12'h108, 8'hFF, 4'h6, 8'h23);
        rq(12'h104, 8'hF0, 4'h7, 8'h44);
        rq(12'h110, 8'h0F, 4'h8, 8'h66);
        idle(2);
        rq(12'hFF8, 8'hC3, 4'hA, 8'h01);   // R4 top quadword
        rq(12'hFFC, 8'h90, 4'hB, 8'h02);   // R3 top dword
        rq(12'h000, 8'h00, 4'hC, 8'h00);   // R5 no bytes enabled
        idle(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule